// File: doc/BRIEF.md
# Pulse-Width Classifying Rate Counter

The block counts events on a bank of trigger inputs, one independent counter per input. Each channel holds a 4-bit counting type. Depending on that type, the channel counts one of three things: pulses whose width, measured in periods of the sampling clock, falls in a chosen class; sub-period glitches that are never seen high on a clock edge; or every clock cycle in which the input is high.

A free-running gate timer marks fixed windows of `GATE_CYCLES` clocks. By default the window is one second at a 40 MHz clock. At the end of each window, every channel copies its running total into a readable latch and restarts from zero.

Software uses a word-addressed register interface. Each channel register holds its type in the top nibble and returns the latched count in the low bits. A control word at offset 0 issues a software reset.

Top module: `pulse_rate_counter`

## Requirements
- R1: After the asynchronous reset, every channel reads 0: type off and latched count 0. Offset 0x00 reads 0.
- R2: Channel k (1..N_CH) sits at byte offset 4*k. Bits 31:28 hold the type, which reads back as written. Bits CNT_W-1:0 return the latched count; with the default CNT_W of 26 these are bits 25:0. Every other bit reads 0, and writes to the count bits have no effect. A word offset beyond the last channel reads 0.
- R3: The running count saturates at 2^CNT_W-1.
- R4: Every GATE_CYCLES cycles, the running count is copied into the latch and the running count restarts from 0. The copy includes an event counted in that same cycle. The latch holds its value until the next copy.
- R5: A pulse's width is the number of consecutive rising clock edges on which the input is sampled high. A pulse is classified on the second clock edge after the input is first sampled low, and it counts in the window that contains that edge.
- R6: The width-class type codes are:
  - 6: width of at least 1 clock.
  - 7: width of exactly 1 clock.
  - 0xA: width of at least 2 clocks.
  - 0xB: width of exactly 2 clocks.
  - 0xE: width of at least 3 clocks.
- R7: Type 5 counts pulses of width 0. These are pulses that rise and fall between two clock edges and are never sampled high.
- R8: Type 0xF counts the clock edges on which the input is sampled high.
- R9: Type 0 and every code not listed in R6 to R8 count nothing.
- R10: Writing offset 0x00 with bit 0 set has three effects. It sets every type to 0, it clears the running counts, and it restarts the gate so that the next copy happens GATE_CYCLES cycles later. Latched values are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling and gate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_i | input | N_CH | Trigger inputs, one per channel |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |

## Verification
The assertions assume three things about the environment:
- Register writes never target a channel while the bench relies on that channel's count staying unchanged.
- A software reset and a gate copy may coincide, with the reset taking priority.
- Inputs are sampled directly by the clock, so they must not change close to a rising edge.

The bench respects these assumptions in the following ways. It drives levels on falling clock edges. It places glitches in the middle of a low half period. It leaves at least one low sample between consecutive pulses or glitches on a channel. It finishes all pulses before the window boundary, except in the one directed test that targets that boundary.

// File: rtl/prc_pkg.sv
package prc_pkg;

  localparam logic [3:0] CT_OFF   = 4'h0;
  localparam logic [3:0] CT_LT1   = 4'h5;
  localparam logic [3:0] CT_GE1   = 4'h6;
  localparam logic [3:0] CT_EQ1   = 4'h7;
  localparam logic [3:0] CT_GE2   = 4'hA;
  localparam logic [3:0] CT_EQ2   = 4'hB;
  localparam logic [3:0] CT_GE3   = 4'hE;
  localparam logic [3:0] CT_LEVEL = 4'hF;

  // w is a width saturated at 3
  function automatic logic width_match(logic [3:0] code, logic [1:0] w);
    case (code)
      CT_LT1:  return w == 2'd0;
      CT_GE1:  return w != 2'd0;
      CT_EQ1:  return w == 2'd1;
      CT_GE2:  return w >= 2'd2;
      CT_EQ2:  return w == 2'd2;
      CT_GE3:  return w == 2'd3;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic code_active(logic [3:0] code);
    case (code)
      CT_LT1, CT_GE1, CT_EQ1, CT_GE2, CT_EQ2, CT_GE3, CT_LEVEL: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/prc_input_capture.sv
module prc_input_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic hi_o,
  output logic rise_o
);

  // toggles on every input rise, even one too short for the clock to see
  logic tog_q;
  always_ff @(posedge pulse_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else         tog_q <= ~tog_q;
  end

  logic hi_q, tog_s, tog_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= 1'b0;
      tog_s <= 1'b0;
      tog_d <= 1'b0;
    end else begin
      hi_q  <= pulse_i;
      tog_s <= tog_q;
      tog_d <= tog_s;
    end
  end

  assign hi_o   = hi_q;
  assign rise_o = tog_s ^ tog_d;

endmodule

// File: rtl/prc_width_classifier.sv
module prc_width_classifier
  import prc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hi_i,
  input  logic       rise_i,
  input  logic [3:0] code_i,
  output logic       inc_o
);

  logic [1:0] run_q;
  logic       pend_q;
  logic       has_run, fire;

  assign has_run = run_q != 2'd0;
  // classify once the input is low and a pulse or an unseen rise is owed
  assign fire    = !hi_i && (has_run || pend_q || rise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 2'd0;
      pend_q <= 1'b0;
    end else begin
      if (hi_i) run_q <= (run_q == 2'd3) ? 2'd3 : run_q + 2'd1;
      else      run_q <= 2'd0;
      // a rise landing on the cycle a real pulse closes is kept for later
      if (fire) pend_q <= rise_i && has_run;
      else      pend_q <= pend_q | rise_i;
    end
  end

  always_comb begin
    if (code_i == CT_LEVEL) inc_o = hi_i;
    else                    inc_o = fire && width_match(code_i, run_q);
  end

endmodule

// File: rtl/prc_gate_timer.sv
module prc_gate_timer #(
  parameter int GATE_CYCLES = 40_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);

  localparam int GW = $clog2(GATE_CYCLES);
  localparam logic [GW-1:0] LAST = GW'(GATE_CYCLES - 1);

  logic [GW-1:0] cnt_q;

  assign tick_o = cnt_q == LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/prc_chan_counter.sv
module prc_chan_counter #(
  parameter int CNT_W = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] run_o,
  output logic [CNT_W-1:0] lat_o
);

  localparam logic [CNT_W-1:0] MAX = '1;

  logic [CNT_W-1:0] run_q, lat_q, run_nxt;

  assign run_nxt = (inc_i && run_q != MAX) ? run_q + 1'b1 : run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      lat_q <= '0;
    end else if (clr_i) begin
      run_q <= '0;
    end else if (tick_i) begin
      lat_q <= run_nxt;
      run_q <= '0;
    end else begin
      run_q <= run_nxt;
    end
  end

  assign run_o = run_q;
  assign lat_o = lat_q;

endmodule

// File: rtl/pulse_rate_counter.sv
module pulse_rate_counter
  import prc_pkg::*;
#(
  parameter int N_CH        = 25,
  parameter int CNT_W       = 26,
  parameter int GATE_CYCLES = 40_000_000,
  parameter int ADDR_W      = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   pulse_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o
);

  localparam int IDX_W = ADDR_W - 2;
  localparam int PAD_W = 28 - CNT_W;

  logic [IDX_W-1:0]            word;
  logic                        aligned, soft_clr, gate_tick;
  logic [N_CH-1:0][3:0]        typ_q;
  logic [N_CH-1:0][CNT_W-1:0]  run_cnt, lat_cnt;
  logic                        unused_wdata;

  assign word         = addr_i[ADDR_W-1:2];
  assign aligned      = addr_i[1:0] == 2'b00;
  assign soft_clr     = wr_en_i && (addr_i == '0) && wdata_i[0];
  assign unused_wdata = ^wdata_i[27:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      typ_q <= '0;
    end else if (soft_clr) begin
      typ_q <= '0;
    end else begin
      for (int k = 0; k < N_CH; k++)
        if (wr_en_i && aligned && word == IDX_W'(k + 1))
          typ_q[k] <= wdata_i[31:28];
    end
  end

  prc_gate_timer #(.GATE_CYCLES(GATE_CYCLES)) u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (soft_clr),
    .tick_o(gate_tick)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic hi, rise, inc;

    prc_input_capture u_cap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pulse_i(pulse_i[g]),
      .hi_o   (hi),
      .rise_o (rise)
    );

    prc_width_classifier u_cls (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .hi_i  (hi),
      .rise_i(rise),
      .code_i(typ_q[g]),
      .inc_o (inc)
    );

    prc_chan_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (soft_clr),
      .tick_i(gate_tick),
      .inc_i (inc),
      .run_o (run_cnt[g]),
      .lat_o (lat_cnt[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N_CH; k++)
      if (aligned && word == IDX_W'(k + 1))
        rdata_o = {typ_q[k], {PAD_W{1'b0}}, lat_cnt[k]};
  end

endmodule

// File: rtl/prc_checker.sv
module prc_checker
  import prc_pkg::*;
#(
  parameter int N_CH        = 25,
  parameter int CNT_W       = 26,
  parameter int GATE_CYCLES = 40_000_000
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       soft_clr_i,
  input logic                       tick_i,
  input logic [N_CH-1:0][3:0]       typ_i,
  input logic [N_CH-1:0][CNT_W-1:0] run_i,
  input logic [N_CH-1:0][CNT_W-1:0] lat_i
);

  localparam logic [CNT_W-1:0] MAX = '1;

  int unsigned since_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  since_q <= 0;
    else if (soft_clr_i || tick_i) since_q <= 0;
    else                          since_q <= since_q + 1;
  end

  assert_gate_period_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> since_q == GATE_CYCLES - 1);

  assert_soft_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_clr_i |=> typ_i == '0);

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    assert_run_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i || soft_clr_i) |=> run_i[i] == '0);

    assert_latch_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(lat_i[i]));

    assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i[i] == MAX && !tick_i && !soft_clr_i) |=> run_i[i] == MAX);

    assert_single_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !soft_clr_i) |=>
        (run_i[i] == $past(run_i[i]) || run_i[i] == $past(run_i[i]) + 1'b1));

    assert_off_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!code_active(typ_i[i]) && !tick_i && !soft_clr_i) |=> $stable(run_i[i]));
  end

endmodule

bind pulse_rate_counter prc_checker #(
  .N_CH(N_CH), .CNT_W(CNT_W), .GATE_CYCLES(GATE_CYCLES)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .soft_clr_i(soft_clr),
  .tick_i    (gate_tick),
  .typ_i     (typ_q),
  .run_i     (run_cnt),
  .lat_i     (lat_cnt)
);

// File: tb/tb_pulse_rate_counter.sv
module tb_pulse_rate_counter;

  localparam int N  = 25;
  localparam int CW = 8;
  localparam int G  = 512;
  localparam int MAXV = (1 << CW) - 1;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [N-1:0] pulse_i;
  logic        wr_en_i;
  logic [6:0]  addr_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;

  pulse_rate_counter #(.N_CH(N), .CNT_W(CW), .GATE_CYCLES(G), .ADDR_W(7)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_i(pulse_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  always #10 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int checks = 0, errors = 0, e0 = 0;
  logic [N-1:0] wave [0:G];
  logic [N-1:0] gl   [0:G];
  int hist [N][8];
  int lsum [N];
  logic [3:0] codes [N];
  logic [3:0] code_tbl [12] = '{4'h0, 4'h5, 4'h6, 4'h7, 4'hA, 4'hB, 4'hE, 4'hF,
                                4'h1, 4'h3, 4'h9, 4'hC};

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired act=%0d exp=done", cyc);
    finish_run();
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // called and returns on a falling edge
  task automatic wr(logic [6:0] a, logic [31:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] v);
    addr_i = a;
    #1 v = rdata_o;
    @(negedge clk_i);
  endtask

  task automatic soft_reset();
    wr(7'h00, 32'h1);
    e0 = cyc;
  endtask

  function automatic string tag_of(logic [3:0] c);
    case (c)
      4'h5: return "R7";
      4'hF: return "R8";
      4'h6, 4'h7, 4'hA, 4'hB, 4'hE: return "R6";
      default: return "R9";
    endcase
  endfunction

  function automatic int exp_of(logic [3:0] c, int ch);
    int s = 0;
    case (c)
      4'h5: s = hist[ch][0];
      4'h6: for (int w = 1; w < 8; w++) s += hist[ch][w];
      4'h7: s = hist[ch][1];
      4'hA: for (int w = 2; w < 8; w++) s += hist[ch][w];
      4'hB: s = hist[ch][2];
      4'hE: for (int w = 3; w < 8; w++) s += hist[ch][w];
      4'hF: s = lsum[ch];
      default: s = 0;
    endcase
    return (s > MAXV) ? MAXV : s;
  endfunction

  task automatic clear_stim();
    for (int j = 0; j <= G; j++) begin wave[j] = '0; gl[j] = '0; end
    for (int c = 0; c < N; c++) begin
      lsum[c] = 0;
      for (int w = 0; w < 8; w++) hist[c][w] = 0;
    end
  endtask

  // drives slots 1..G of the window opened at e0; slot j is sampled at edge e0+j
  task automatic drive();
    while (cyc <= e0 + G - 1) begin
      int j = cyc + 1 - e0;
      pulse_i = wave[j];
      if (|gl[j]) begin
        #4 pulse_i = wave[j] | gl[j];
        #4 pulse_i = wave[j];
      end
      @(negedge clk_i);
    end
    pulse_i = '0;
  endtask

  task automatic build_random();
    clear_stim();
    for (int c = 0; c < N; c++) begin
      int t = 64;
      forever begin
        int k;
        t += 1 + int'($urandom % 3);
        if (t >= G - 12) break;
        k = int'($urandom % 7);
        if (k == 0) begin
          gl[t][c] = 1'b1; hist[c][0]++; t++;
        end else begin
          if (t + k >= G - 12) break;
          for (int x = 0; x < k; x++) wave[t + x][c] = 1'b1;
          hist[c][k]++; lsum[c] += k; t += k;
        end
      end
    end
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20080718));
    rst_ni = 1'b0; pulse_i = '0; wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: reset state
    for (int k = 1; k <= N; k++) begin rd(7'(4 * k), v); check("R1 chan", v, 32'h0); end
    rd(7'h00, v); check("R1 ctrl", v, 32'h0);

    // R2: field layout and decode
    wr(7'h04, 32'h6FFF_FFFF); rd(7'h04, v); check("R2 type+cnt bits", v, 32'h6000_0000);
    wr(7'h64, 32'hB000_0000); rd(7'h64, v); check("R2 last chan", v, 32'hB000_0000);
    wr(7'h68, 32'hF000_0000); rd(7'h68, v); check("R2 beyond last", v, 32'h0);
    rd(7'h05, v); check("R2 misaligned", v, 32'h0);

    // R10: software reset turns types off
    soft_reset();
    rd(7'h04, v); check("R10 chan1 off", v, 32'h0);
    rd(7'h64, v); check("R10 chan25 off", v, 32'h0);

    // R5 R6 R7 R8 R9: random windows, then R4 hold and clear
    for (int win = 0; win < 3; win++) begin
      build_random();
      soft_reset();
      for (int c = 0; c < N; c++) begin
        codes[c] = (win == 0) ? code_tbl[c % 12] : code_tbl[$urandom % 12];
        wr(7'(4 * (c + 1)), {codes[c], 28'h0});
      end
      drive();
      for (int c = 0; c < N; c++) begin
        rd(7'(4 * (c + 1)), v);
        check(tag_of(codes[c]), v, {codes[c], 20'h0, 8'(exp_of(codes[c], c))});
      end
      while (cyc < e0 + G + 200) @(negedge clk_i);
      for (int c = 0; c < N; c++) begin
        rd(7'(4 * (c + 1)), v);
        check("R4 hold", v, {codes[c], 20'h0, 8'(exp_of(codes[c], c))});
      end
      while (cyc < e0 + 2 * G) @(negedge clk_i);
      for (int c = 0; c < N; c++) begin
        rd(7'(4 * (c + 1)), v);
        check("R4 cleared", v, {codes[c], 28'h0});
      end
    end

    // R5: classification edge at the window boundary
    clear_stim();
    soft_reset();
    wr(7'h0C, 32'h7000_0000);
    wr(7'h10, 32'h7000_0000);
    wave[G - 2][2] = 1'b1;
    wave[G - 1][3] = 1'b1;
    drive();
    rd(7'h0C, v); check("R5 last edge in", v, 32'h7000_0001);
    rd(7'h10, v); check("R5 next window", v, 32'h7000_0000);
    while (cyc < e0 + 2 * G) @(negedge clk_i);
    rd(7'h0C, v); check("R5 in gone", v, 32'h7000_0000);
    rd(7'h10, v); check("R5 spill", v, 32'h7000_0001);

    // R3 saturation and R8 plain level count
    clear_stim();
    soft_reset();
    wr(7'h04, 32'hF000_0000);
    wr(7'h08, 32'hF000_0000);
    for (int j = 64; j < 464; j++) wave[j][0] = 1'b1;
    for (int j = 100; j < 200; j++) wave[j][1] = 1'b1;
    drive();
    rd(7'h04, v); check("R3 saturate", v, {4'hF, 20'h0, 8'(MAXV)});
    rd(7'h08, v); check("R8 level", v, 32'hF000_0064);

    finish_run();
  end

endmodule